// File: doc/BRIEF.md
# Chunked Control Mailbox Responder

This block is the device-side end of a command mailbox. A host reaches it through a plain 32-bit word-addressed read/write port. The port exposes three registers and a small data window:

- a command register, which holds the opcode and the queue index;
- a control/status register, which holds the chunk size, the busy and ready flags and the error code;
- a reserved word;
- the data window.

The host posts a command by writing a nonzero opcode. The block hands the command to an internal producer. For the payload command it gathers the producer's words into the window one chunk at a time. Each chunk is flagged ready, and the block waits for the host to clear that flag before it gathers the next chunk.

Commands without payload are acknowledged with a zero-length ready chunk that carries the producer's status code. The block releases the command register only after the host has cleared the ready flag. A nonzero error code ends a payload transfer at once. In legacy mode the control register is left alone, and a command is acknowledged only by the command register returning to zero.

Every read returns its data one clock after the read strobe. Host writes into the window are dropped.

Top module: `cmb_mailbox`

## Requirements
- R1: After reset the command register (word 0), the control register (word 1) and the reserved word (word 2) all read zero.
- R2: The command register holds the opcode in bits 15:0 and the queue index in bits 31:16. Writing a nonzero opcode while the register is zero starts a command, and the written value reads back while the command runs. A command that goes to the producer raises `cmd_valid` for one cycle, with the opcode and index on `cmd_opcode` and `cmd_qidx`.
- R3: A write to the command register while it is nonzero leaves its value unchanged.
- R4: The control register has size in bits 15:0, busy in bit 16, ready in bit 17 and error in bits 27:18. Opcode 2 returns the producer's words in order. They are split into chunks of at most WIN_WORDS words, and the chunk's word i is read at word address 3+i. Each chunk sets ready with size equal to its word count, and busy stays 1 while more chunks follow.
- R5: While a chunk is flagged ready with busy set, `src_ready` stays low and the control register does not change until the host writes the control register with bit 17 clear.
- R6: A chunk is the last one when the producer marks its final beat or when the requested word count is reached. The last chunk shows busy 0 and ready 1, and the command register reads zero.
- R7: A producer beat with a nonzero error code during a payload transfer ends it. The control register then shows that code in bits 27:18, with busy 0, ready 1 and size 0, and the command register reads zero.
- R8: Opcodes 1, 3 and 4 are acknowledged after one producer beat. The control register shows ready 1, size 0, busy 0 and the beat's error code, and the opcode is kept until the host clears bit 17. The command register then reads zero.
- R9: Any other nonzero opcode raises no `cmd_valid`. It is acknowledged like R8, with error code UNK_ERR (default 5).
- R10: With `legacy` high, a command raises `cmd_valid`, and the command register clears after the producer's final beat. The control register is left unchanged.
- R11: While no command is active, a control register write loads the size field from bits 15:0 and clears busy, ready and error.
- R12: Opcode 2 with a requested size of zero completes at once. The control register shows ready 1, busy 0 and size 0, and neither the command register nor `cmd_valid` is ever raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| legacy | input | 1 | Select acknowledge-by-clearing mode |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | ADDR_W | Host word address |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Read data, valid one cycle after `bus_rd` |
| src_valid | input | 1 | Producer beat valid |
| src_data | input | 32 | Producer payload word |
| src_last | input | 1 | Final producer beat of the command |
| src_err | input | 10 | Producer error code, zero for success |
| src_ready | output | 1 | Block accepts a producer beat |
| cmd_valid | output | 1 | One-cycle pulse when a command reaches the producer |
| cmd_opcode | output | 16 | Opcode of the pulsed command |
| cmd_qidx | output | 16 | Queue index of the pulsed command |

## Verification
The assertions assume the following about the inputs:
- the host never writes and reads in the same cycle;
- the producer offers beats only after a `cmd_valid` pulse;
- the producer never sends more payload beats than the host requested.

The bench keeps to these assumptions. The host side is driven only through single-strobe write and read tasks. The producer process is triggered solely by the `cmd_valid` pulse, and the number of beats it sends is set by each test so that it never exceeds the requested size.

// File: rtl/cmb_pkg.sv
package cmb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FILL, ST_SHOW, ST_ACK, ST_HOLD, ST_LEG
  } cmb_state_e;

  localparam int BIT_BUSY = 16;
  localparam int BIT_RDY  = 17;
  localparam int ERR_LO   = 18;
  localparam int ERR_W    = 10;

  localparam logic [15:0] OPC_DESTROY = 16'd1;
  localparam logic [15:0] OPC_QSTATE  = 16'd2;
  localparam logic [15:0] OPC_SUSPEND = 16'd3;
  localparam logic [15:0] OPC_RESUME  = 16'd4;
endpackage

// File: rtl/cmb_window.sv
module cmb_window #(
  parameter int WIN_WORDS = 8,
  parameter int DW        = 32,
  localparam int AW       = (WIN_WORDS > 1) ? $clog2(WIN_WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [WIN_WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

  // R4: chunk words land inside the window
  p_wr_range_r4: assert property (@(posedge clk) disable iff (rst)
    we |-> (int'(waddr) < WIN_WORDS));
endmodule

// File: rtl/cmb_seq.sv
module cmb_seq
  import cmb_pkg::*;
#(
  parameter int          WIN_WORDS = 8,
  parameter logic [9:0]  UNK_ERR   = 10'd5,
  localparam int AW = (WIN_WORDS > 1) ? $clog2(WIN_WORDS) : 1,
  localparam int CW = $clog2(WIN_WORDS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          legacy_i,
  input  logic          wr_op_i,
  input  logic          wr_ctl_i,
  input  logic [31:0]   wdata_i,
  input  logic          src_valid_i,
  input  logic          src_last_i,
  input  logic [9:0]    src_err_i,
  output logic          src_ready_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_waddr_o,
  output logic [31:0]   op_o,
  output logic [31:0]   ctl_o,
  output logic          cmd_valid_o,
  output logic [15:0]   cmd_opcode_o,
  output logic [15:0]   cmd_qidx_o
);
  cmb_state_e    st_q;
  logic [31:0]   op_q;
  logic [15:0]   size_q, rem_q;
  logic          busy_q, rdy_q;
  logic [9:0]    err_q;
  logic [CW-1:0] cnt_q;
  logic          fin, close;

  assign src_ready_o = (st_q == ST_FILL) || (st_q == ST_ACK) || (st_q == ST_LEG);
  assign mem_we_o    = (st_q == ST_FILL) && src_valid_i && (src_err_i == '0);
  assign mem_waddr_o = cnt_q[AW-1:0];
  assign fin         = src_last_i || (rem_q == 16'd1);
  assign close       = fin || (int'(cnt_q) == WIN_WORDS - 1);
  assign op_o        = op_q;
  assign ctl_o       = {4'b0, err_q, rdy_q, busy_q, size_q};
  assign cmd_opcode_o = op_q[15:0];
  assign cmd_qidx_o   = op_q[31:16];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE; op_q <= '0; size_q <= '0; rem_q <= '0;
      busy_q <= 1'b0; rdy_q <= 1'b0; err_q <= '0; cnt_q <= '0;
      cmd_valid_o <= 1'b0;
    end else begin
      cmd_valid_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (wr_ctl_i) begin
            size_q <= wdata_i[15:0];
            busy_q <= 1'b0; rdy_q <= 1'b0; err_q <= '0;
          end
          if (wr_op_i && wdata_i[15:0] != '0) begin
            if (legacy_i) begin
              op_q <= wdata_i; cmd_valid_o <= 1'b1; st_q <= ST_LEG;
            end else if (wdata_i[15:0] == OPC_QSTATE) begin
              if (size_q == '0) begin
                rdy_q <= 1'b1; busy_q <= 1'b0; err_q <= '0;
              end else begin
                op_q <= wdata_i; cmd_valid_o <= 1'b1; st_q <= ST_FILL;
                busy_q <= 1'b1; rdy_q <= 1'b0; err_q <= '0;
                rem_q <= size_q; cnt_q <= '0;
              end
            end else if (wdata_i[15:0] == OPC_DESTROY || wdata_i[15:0] == OPC_SUSPEND ||
                         wdata_i[15:0] == OPC_RESUME) begin
              op_q <= wdata_i; cmd_valid_o <= 1'b1; st_q <= ST_ACK;
              busy_q <= 1'b1; rdy_q <= 1'b0; err_q <= '0;
            end else begin
              op_q <= wdata_i; st_q <= ST_HOLD;
              size_q <= '0; busy_q <= 1'b0; rdy_q <= 1'b1; err_q <= UNK_ERR;
            end
          end
        end
        ST_FILL: begin
          if (src_valid_i) begin
            if (src_err_i != '0) begin
              err_q <= src_err_i; size_q <= '0; rdy_q <= 1'b1; busy_q <= 1'b0;
              op_q <= '0; st_q <= ST_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
              rem_q <= rem_q - 16'd1;
              if (close) begin
                size_q <= 16'(cnt_q) + 16'd1;
                rdy_q  <= 1'b1;
                cnt_q  <= '0;
                if (fin) begin
                  busy_q <= 1'b0; op_q <= '0; st_q <= ST_IDLE;
                end else begin
                  st_q <= ST_SHOW;
                end
              end
            end
          end
        end
        ST_SHOW: if (wr_ctl_i && !wdata_i[BIT_RDY]) begin
          rdy_q <= 1'b0; st_q <= ST_FILL;
        end
        ST_ACK: if (src_valid_i) begin
          size_q <= '0; rdy_q <= 1'b1; busy_q <= 1'b0; err_q <= src_err_i;
          st_q <= ST_HOLD;
        end
        ST_HOLD: if (wr_ctl_i && !wdata_i[BIT_RDY]) begin
          rdy_q <= 1'b0; op_q <= '0; st_q <= ST_IDLE;
        end
        ST_LEG: if (src_valid_i && src_last_i) begin
          op_q <= '0; st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R3: a running command's register only ever changes by clearing
  p_op_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (op_q != '0) |=> (op_q == $past(op_q) || op_q == '0));
  // R5: no producer beat is taken while a chunk waits for the host
  p_no_fill_r5: assert property (@(posedge clk) disable iff (rst)
    (ctl_o[BIT_RDY] && ctl_o[BIT_BUSY]) |-> !src_ready_o);
  // R7: a reported error always means the transfer is over
  p_err_done_r7: assert property (@(posedge clk) disable iff (rst)
    (ctl_o[ERR_LO +: ERR_W] != '0) |-> !ctl_o[BIT_BUSY]);
  // R4: a presented chunk never exceeds the window
  p_chunk_max_r4: assert property (@(posedge clk) disable iff (rst)
    (ctl_o[BIT_RDY] && st_q != ST_IDLE && st_q != ST_LEG) |-> (int'(ctl_o[15:0]) <= WIN_WORDS));
  // R10: legacy commands leave the control flags alone
  p_leg_ctl_r10: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_LEG) |=> $stable(ctl_o));
endmodule

// File: rtl/cmb_mailbox.sv
module cmb_mailbox #(
  parameter int         WIN_WORDS = 8,
  parameter int         ADDR_W    = 4,
  parameter logic [9:0] UNK_ERR   = 10'd5,
  localparam int AW       = (WIN_WORDS > 1) ? $clog2(WIN_WORDS) : 1,
  localparam int WIN_BASE = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              legacy,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              src_valid,
  input  logic [31:0]       src_data,
  input  logic              src_last,
  input  logic [9:0]        src_err,
  output logic              src_ready,
  output logic              cmd_valid,
  output logic [15:0]       cmd_opcode,
  output logic [15:0]       cmd_qidx
);
  logic [31:0]       op_w, ctl_w, win_rd, reg_q;
  logic              we_w, win_hit, sel_win_q;
  logic [AW-1:0]     waddr_w;
  logic [ADDR_W-1:0] off;

  assign off     = bus_addr - ADDR_W'(WIN_BASE);
  assign win_hit = (int'(bus_addr) >= WIN_BASE) && (int'(bus_addr) < WIN_BASE + WIN_WORDS);

  cmb_seq #(.WIN_WORDS(WIN_WORDS), .UNK_ERR(UNK_ERR)) u_seq (
    .clk, .rst, .legacy_i(legacy),
    .wr_op_i(bus_wr && bus_addr == '0),
    .wr_ctl_i(bus_wr && bus_addr == ADDR_W'(1)),
    .wdata_i(bus_wdata),
    .src_valid_i(src_valid), .src_last_i(src_last), .src_err_i(src_err),
    .src_ready_o(src_ready), .mem_we_o(we_w), .mem_waddr_o(waddr_w),
    .op_o(op_w), .ctl_o(ctl_w),
    .cmd_valid_o(cmd_valid), .cmd_opcode_o(cmd_opcode), .cmd_qidx_o(cmd_qidx)
  );

  cmb_window #(.WIN_WORDS(WIN_WORDS), .DW(32)) u_win (
    .clk, .rst, .we(we_w), .waddr(waddr_w), .wdata(src_data),
    .re(bus_rd && win_hit), .raddr(off[AW-1:0]), .rdata(win_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q <= '0; sel_win_q <= 1'b0;
    end else if (bus_rd) begin
      sel_win_q <= win_hit;
      if (bus_addr == '0)              reg_q <= op_w;
      else if (bus_addr == ADDR_W'(1)) reg_q <= ctl_w;
      else                             reg_q <= '0;
    end
  end

  assign bus_rdata = sel_win_q ? win_rd : reg_q;

  // R1: read data is driven by the register path right after reset
  p_rst_read_r1: assert property (@(posedge clk) rst |=> (bus_rdata == '0));
endmodule

// File: tb/cmb_mailbox_bench.sv
module cmb_mailbox_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 8;

  logic clk = 0, rst = 1, legacy = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [3:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic src_valid = 0, src_last = 0, src_ready;
  logic [31:0] src_data = 0;
  logic [9:0] src_err = 0;
  logic cmd_valid;
  logic [15:0] cmd_opcode, cmd_qidx;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmb_mailbox #(.WIN_WORDS(WIN), .ADDR_W(4)) u_cmb_mailbox (.*);

  int checks = 0, errors = 0;
  logic [31:0] exp_q [$];
  int p_n = 0, p_err_at = -1, p_delay = 0;
  logic [9:0] p_err_code = 0;
  logic [31:0] p_base = 0;
  bit p_push = 0;
  int cmd_seen = 0;
  logic [15:0] last_op, last_qidx;
  int sizes [$];
  int busys [$];
  logic [31:0] end_ctl;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic poll(output logic [31:0] v);
    for (int k = 0; k < 300; k++) begin
      rd(4'd1, v);
      if (v[17] || v[27:18] != 0) break;
    end
  endtask

  // producer: stimulus side, pushes expected words into the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (cmd_valid) begin
        cmd_seen++; last_op = cmd_opcode; last_qidx = cmd_qidx;
        repeat (p_delay) @(negedge clk);
        for (int i = 0; i < p_n; i++) begin
          if (i > 0) @(negedge clk);
          src_valid = 1; src_data = p_base + i; src_last = (i == p_n - 1);
          src_err = (i == p_err_at) ? p_err_code : 10'd0;
          while (!src_ready) @(negedge clk);
          if (p_push && i != p_err_at) exp_q.push_back(p_base + i);
        end
        @(negedge clk); src_valid = 0; src_last = 0; src_err = 0;
      end
    end
  end

  // host monitor: drains chunks and compares with the scoreboard
  task automatic pull();
    logic [31:0] v, w, v2;
    sizes.delete(); busys.delete();
    for (int c = 0; c < 20; c++) begin
      poll(v);
      end_ctl = v;
      if (v[27:18] != 0) break;
      sizes.push_back(v[15:0]); busys.push_back(v[16]);
      chk(v[15:0] <= WIN, "R4 chunk size bound", v[15:0], WIN);
      for (int i = 0; i < v[15:0]; i++) begin
        rd(4'(3 + i), w);
        if (exp_q.size() == 0) chk(0, "R4 unexpected word", w, 0);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          chk(w == e, "R4 window word", w, e);
        end
      end
      if (!v[16]) break;
      repeat (3) @(negedge clk);
      chk(src_ready == 0, "R5 no fill while ready", src_ready, 0);
      rd(4'd1, v2);
      chk(v2 == v, "R5 ctl held", v2, v);
      wr(4'd1, v & ~32'h0002_0000);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    rd(4'd0, v); chk(v == 0, "R1 op reset", v, 0);
    rd(4'd1, v); chk(v == 0, "R1 ctl reset", v, 0);
    rd(4'd2, v); chk(v == 0, "R1 reserved", v, 0);

    // R11: idle control write
    wr(4'd1, 32'h0FFF_0005); rd(4'd1, v);
    chk(v == 32'h5, "R11 idle ctl load", v, 32'h5);

    // multi-chunk payload 20 words
    p_n = 20; p_err_at = -1; p_base = 32'hA000_0000; p_push = 1; p_delay = 0;
    wr(4'd1, 20); wr(4'd0, 32'h0007_0002);
    rd(4'd0, v); chk(v == 32'h0007_0002, "R2 op readback", v, 32'h0007_0002);
    wr(4'd0, 32'h0000_0001); rd(4'd0, v);
    chk(v == 32'h0007_0002, "R3 busy op write ignored", v, 32'h0007_0002);
    chk(last_op == 2 && last_qidx == 7, "R2 cmd fields", {last_qidx, last_op}, 32'h0007_0002);
    pull();
    chk(sizes.size() == 3, "R4 chunk count", sizes.size(), 3);
    if (sizes.size() == 3) begin
      chk(sizes[0] == 8 && sizes[1] == 8 && sizes[2] == 4, "R4 chunk sizes", sizes[2], 4);
      chk(busys[0] == 1 && busys[1] == 1 && busys[2] == 0, "R6 busy flags", busys[2], 0);
    end
    rd(4'd0, v); chk(v == 0, "R6 op cleared", v, 0);
    chk(end_ctl[17] == 1, "R6 final ready", end_ctl, 32'h0002_0004);

    // exactly one full window
    p_n = 8; p_base = 32'hB000_0000;
    wr(4'd1, 8); wr(4'd0, 32'h0001_0002); pull();
    chk(sizes.size() == 1 && end_ctl == 32'h0002_0008, "R6 full window final", end_ctl, 32'h0002_0008);

    // producer ends early
    p_n = 3; p_base = 32'hC000_0000;
    wr(4'd1, 12); wr(4'd0, 32'h0002_0002); pull();
    chk(end_ctl == 32'h0002_0003, "R6 early last", end_ctl, 32'h0002_0003);
    rd(4'd0, v); chk(v == 0, "R6 op cleared early", v, 0);

    // error path
    p_n = 10; p_err_at = 9; p_err_code = 10'h2A; p_base = 32'hD000_0000;
    wr(4'd1, 16); wr(4'd0, 32'h0003_0002); pull();
    chk(end_ctl == ((32'h2A << 18) | 32'h0002_0000), "R7 error ctl", end_ctl, (32'h2A << 18) | 32'h0002_0000);
    rd(4'd0, v); chk(v == 0, "R7 op cleared", v, 0);
    exp_q.delete();

    // payload-less commands
    p_push = 0; p_n = 1; p_err_at = -1;
    wr(4'd1, 0); wr(4'd0, 32'h0000_0003); poll(v);
    chk(v == 32'h0002_0000, "R8 suspend ack", v, 32'h0002_0000);
    rd(4'd0, v); chk(v == 3, "R8 op held", v, 3);
    wr(4'd1, 0); rd(4'd0, v); chk(v == 0, "R8 op released", v, 0);
    p_err_at = 0; p_err_code = 10'h11;
    wr(4'd1, 0); wr(4'd0, 32'h0000_0001); poll(v);
    chk(v == ((32'h11 << 18) | 32'h0002_0000), "R8 destroy error code", v, (32'h11 << 18) | 32'h0002_0000);
    wr(4'd1, 0); rd(4'd0, v); chk(v == 0, "R8 op released err", v, 0);
    p_err_at = -1;

    // unknown opcode
    n0 = cmd_seen;
    wr(4'd1, 0); wr(4'd0, 32'h0000_0009); poll(v);
    chk(v == ((32'd5 << 18) | 32'h0002_0000), "R9 unknown ack", v, (32'd5 << 18) | 32'h0002_0000);
    chk(cmd_seen == n0, "R9 no cmd pulse", cmd_seen, n0);
    wr(4'd1, 0); rd(4'd0, v); chk(v == 0, "R9 op released", v, 0);

    // zero-size payload request
    n0 = cmd_seen;
    wr(4'd1, 0); wr(4'd0, 32'h0000_0002); rd(4'd1, v);
    chk(v == 32'h0002_0000, "R12 zero size ctl", v, 32'h0002_0000);
    rd(4'd0, v); chk(v == 0, "R12 op zero", v, 0);
    chk(cmd_seen == n0, "R12 no cmd pulse", cmd_seen, n0);

    // legacy
    legacy = 1; p_delay = 5;
    wr(4'd1, 32'h33); n0 = cmd_seen;
    wr(4'd0, 32'h0000_0004); rd(4'd0, v);
    chk(v == 4, "R10 legacy op pending", v, 4);
    repeat (12) @(negedge clk);
    rd(4'd0, v); chk(v == 0, "R10 legacy op cleared", v, 0);
    chk(cmd_seen == n0 + 1, "R10 legacy cmd pulse", cmd_seen, n0 + 1);
    rd(4'd1, v); chk(v == 32'h33, "R10 legacy ctl untouched", v, 32'h33);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule